// File: doc/BRIEF.md
# Systolic FIR Multiply-Add Chain

This block is a pipelined finite-impulse-response filter built from N identical multiply-add processing elements in a systolic arrangement. Signed samples enter at one end of a register chain. Each element takes a sample from its own tap of that chain, multiplies it by a fixed coefficient, and adds the product to the registered partial sum handed on by the element before it. Samples and partial sums move the same way, from the element that holds coefficient 0 toward the element that holds coefficient N-1. The last partial sum is the filter output.

The sample chain holds two registers per element and the sum chain holds one. Element k therefore sees a sample that is two cycles older than the one element k-1 sees, while its partial sum arrives one cycle later. The net skew of one sample per element lines up c(k) with x(n-k) exactly when the running sum reaches element k. No adder tree is needed and no sample is broadcast to every element. The coefficients are a build-time parameter. A cycle without a valid sample feeds a zero into the chain, so the filter keeps running at one step per clock.

Top module: `sys_fir`

## Requirements
- R1: While `rst_n` is low at a rising edge, all sample, sum and valid registers clear, so `out_valid` = 0 and `out_sum` = 0 after that edge, including when data is in flight.
- R2: A sample taken at rising edge e contributes its first output term after edge e+N, and not earlier.
- R3: `out_valid` after edge e+N equals `in_valid` at edge e; `out_valid` is never high without a matching earlier accepted sample.
- R4: A single sample of value 1 followed by idle cycles produces `out_sum` = c(k) after edge e+N+k, for k = 0 .. N-1.
- R5: For any stream, `out_sum` after edge e+N equals the sum over k of c(k)·x(e-k), where x(j) is the sample entering at edge j (zero before reset release).
- R6: When `in_valid` is low at an edge, `in_sample` is ignored and a zero sample enters the chain in its place.
- R7: `out_sum` is exact two's complement with DW+CW+ceil(log2 N) bits, so full-scale samples combined with the most negative coefficient do not wrap.
- R8: Coefficient c(k) is the two's-complement field at bits [k·CW +: CW] of parameter `COEFS`, with c(0) applied to the newest sample.
- R9: The chain advances on every clock: after 2N consecutive edges with `in_valid` low, `out_sum` = 0, and after N+1 such edges `out_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | High when `in_sample` carries a real sample |
| in_sample | input | DW | Signed input sample |
| out_valid | output | 1 | High when `out_sum` belongs to a valid input sample |
| out_sum | output | DW+CW+ceil(log2 N) | Signed filter output |

## Verification
Every result for a sample taken at rising edge e is due after edge e+N. For an impulse, the tap c(k) appears after edge e+N+k, and a stream goes to zero 2N edges after the last valid sample. The bench numbers the rising edges from the release of reset and logs the zero-substituted sample and the valid bit applied at each edge. At the falling edge after edge E it compares both outputs with the convolution and the valid bit recorded at edge E-N. The scenario checks for latency, impulse taps, full-scale sums and flushing are placed on the tick whose index follows from the same count.

// File: rtl/sys_fir.sv
`timescale 1ns/1ps
module sys_fir #(
  parameter int N  = 8,
  parameter int DW = 12,
  parameter int CW = 10,
  parameter logic [N*CW-1:0] COEFS = {10'sd5, -10'sd12, 10'sd40, 10'sd97,
                                      10'sd97, 10'sd40, -10'sd12, 10'sd5}
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 in_valid,
  input  logic signed [DW-1:0]                 in_sample,
  output logic                                 out_valid,
  output logic signed [DW+CW+$clog2(N)-1:0]    out_sum
);
  localparam int AW    = DW + CW + $clog2(N);
  localparam int PW    = DW + CW;
  localparam int XTAPS = 2*N - 1;

  logic signed [DW-1:0] xs   [XTAPS];
  logic signed [AW-1:0] acc  [N];
  logic signed [PW-1:0] prod [N];
  logic        [N:0]    vpipe;

  wire signed [DW-1:0] x_in = in_valid ? in_sample : '0;

  // sample chain: two registers per element, element k reads tap 2k
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < XTAPS; j++) xs[j] <= '0;
      vpipe <= '0;
    end else begin
      xs[0] <= x_in;
      for (int j = 1; j < XTAPS; j++) xs[j] <= xs[j-1];
      vpipe <= {vpipe[N-1:0], in_valid};
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_pe
    wire signed [CW-1:0] coef = COEFS[k*CW +: CW];
    assign prod[k] = PW'(xs[2*k]) * PW'(coef);
  end

  // sum chain: one register per element
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) acc[k] <= '0;
    end else begin
      acc[0] <= AW'(prod[0]);
      for (int k = 1; k < N; k++) acc[k] <= acc[k-1] + AW'(prod[k]);
    end
  end

  assign out_sum   = acc[N-1];
  assign out_valid = vpipe[N];
endmodule

// File: rtl/sys_fir_chk.sv
`timescale 1ns/1ps
module sys_fir_chk #(
  parameter int N  = 8,
  parameter int DW = 12,
  parameter int CW = 10,
  parameter logic [N*CW-1:0] COEFS = '0
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              in_valid,
  input logic                              out_valid,
  input logic signed [DW+CW+$clog2(N)-1:0] out_sum
);
  function automatic longint abs_coef_sum();
    longint s = 0;
    for (int k = 0; k < N; k++) begin
      longint c = longint'($signed(COEFS[k*CW +: CW]));
      s += (c < 0) ? -c : c;
    end
    return s;
  endfunction

  localparam longint BOUND = abs_coef_sum() * (longint'(1) << (DW-1));

  int   idle_run;
  int   inflight;
  logic rst_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_run <= 0;
      inflight <= 0;
    end else begin
      idle_run <= in_valid ? 0 : ((idle_run < 2*N) ? idle_run + 1 : idle_run);
      inflight <= inflight + 32'(in_valid) - 32'(out_valid);
    end
  end

  always_ff @(posedge clk) rst_seen <= !rst_n;

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rst_seen |-> (!out_valid && out_sum == '0)); // R1
  AST_VALID_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= N + 1); // R3
  AST_VALID_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> inflight > 0); // R3
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    idle_run >= N + 1 |-> !out_valid); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    idle_run >= 2*N |-> out_sum == '0); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(out_sum) <= BOUND) && ($signed(out_sum) >= -BOUND)); // R7
endmodule

bind sys_fir sys_fir_chk #(.N(N), .DW(DW), .CW(CW), .COEFS(COEFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .out_valid(out_valid), .out_sum(out_sum)
);

// File: tb/sim_sys_fir.sv
`timescale 1ns/1ps
module sim_sys_fir;
  localparam int N  = 8;
  localparam int DW = 12;
  localparam int CW = 10;
  localparam int AW = DW + CW + $clog2(N);
  localparam int HMAX = 4096;
  // c(0)..c(7) = 7, -3, 120, -512, 511, 64, -1, 250 ; c(0) in the low field
  localparam logic [N*CW-1:0] TB_COEFS = {10'sd250, -10'sd1, 10'sd64, 10'sd511,
                                          10'h200, 10'sd120, -10'sd3, 10'sd7};
  int cf [N] = '{7, -3, 120, -512, 511, 64, -1, 250};

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic signed [DW-1:0] in_sample = '0;
  logic out_valid;
  logic signed [AW-1:0] out_sum;

  sys_fir #(.N(N), .DW(DW), .CW(CW), .COEFS(TB_COEFS)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_sum(out_sum)
  );

  always #10 clk = ~clk;

  int n_run = 0, n_fail = 0, ecount = 0;
  longint xh [HMAX];
  bit     vh [HMAX];
  bit     done = 0;
  int unsigned rng = 32'h1234_5678;

  function automatic longint model_y(int e);
    longint s = 0;
    for (int k = 0; k < N; k++) begin
      int idx = e - N - k;
      if (idx >= 0) s += longint'(cf[k]) * xh[idx];
    end
    return s;
  endfunction

  function automatic bit model_v(int e);
    return (e - N >= 0) ? vh[e - N] : 1'b0;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // at a falling edge: drive, take one rising edge, compare at the next falling edge
  task automatic tick(bit v, logic signed [DW-1:0] s, string req);
    int e;
    in_valid  = v;
    in_sample = s;
    xh[ecount] = v ? longint'(s) : 0;
    vh[ecount] = v;
    @(posedge clk);
    e = ecount;
    ecount++;
    @(negedge clk);
    check(out_valid == model_v(e), req, "out_valid vs model", longint'(out_valid), longint'(model_v(e)));
    check(longint'(out_sum) == model_y(e), req, "out_sum vs model", longint'(out_sum), model_y(e));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", longint'(out_valid), 0);
    check(out_sum == '0, "R1", "out_sum after reset", longint'(out_sum), 0);
    for (int i = 0; i < HMAX; i++) begin xh[i] = 0; vh[i] = 0; end
    ecount = 0;
    rst_n = 1'b1;
  endtask

  function automatic logic signed [DW-1:0] rnd();
    rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
    return rng[DW-1:0];
  endfunction

  task automatic t_reset_midstream();
    do_reset();
    for (int i = 0; i < N + 3; i++) tick(1'b1, rnd(), "R5");
    do_reset(); // R1 with data in flight
  endtask

  task automatic t_latency();
    int first = -1;
    do_reset();
    tick(1'b1, 12'sd100, "R2");
    for (int i = 1; i <= N + 2; i++) begin
      tick(1'b0, '0, "R3");
      if (out_valid && first < 0) first = i;
    end
    check(first == N, "R2", "edges to first valid", first, N);
  endtask

  task automatic t_impulse();
    do_reset();
    tick(1'b1, 12'sd1, "R4");
    for (int i = 1; i < 2*N; i++) begin
      tick(1'b0, '0, "R4");
      if (i >= N) check(longint'(out_sum) == cf[i-N], "R4 R8", "impulse tap", longint'(out_sum), cf[i-N]);
    end
  endtask

  task automatic t_step();
    longint tot = 0;
    do_reset();
    for (int k = 0; k < N; k++) tot += cf[k];
    for (int i = 0; i < 3*N; i++) tick(1'b1, 12'sd300, "R5");
    check(longint'(out_sum) == 300*tot, "R5", "step steady value", longint'(out_sum), 300*tot);
  endtask

  task automatic t_random();
    do_reset();
    for (int i = 0; i < 200; i++) tick(1'b1, rnd(), "R5");
  endtask

  task automatic t_gaps();
    do_reset();
    for (int i = 0; i < 60; i++) tick(i[0], i[0] ? rnd() : 12'sd2047, "R6");
    for (int i = 0; i < 2*N; i++) tick(1'b0, -12'sd2048, "R6");
    check(out_sum == '0, "R6", "ignored samples leave zero", longint'(out_sum), 0);
    check(out_valid == 1'b0, "R6", "no valid from ignored samples", longint'(out_valid), 0);
  endtask

  task automatic t_fullscale(bit positive);
    longint exp = 0;
    do_reset();
    for (int i = 0; i < N; i++) begin
      int k = N - 1 - i;
      logic signed [DW-1:0] s;
      s = ((cf[k] < 0) == positive) ? -12'sd2048 : 12'sd2047;
      exp += longint'(cf[k]) * longint'(s);
      tick(1'b1, s, "R7");
    end
    for (int i = 1; i <= N; i++) tick(1'b0, '0, "R7");
    check(longint'(out_sum) == exp, "R7", positive ? "full-scale positive" : "full-scale negative",
          longint'(out_sum), exp);
  endtask

  task automatic t_flush();
    do_reset();
    for (int i = 0; i < 20; i++) tick(1'b1, rnd(), "R9");
    for (int i = 0; i < N + 1; i++) tick(1'b0, '0, "R9");
    check(out_valid == 1'b0, "R9", "valid drained", longint'(out_valid), 0);
    for (int i = 0; i < N - 1; i++) tick(1'b0, '0, "R9");
    check(out_sum == '0, "R9", "sum flushed", longint'(out_sum), 0);
    tick(1'b1, 12'sd5, "R9");
    for (int i = 0; i < N; i++) tick(1'b0, '0, "R9");
    check(longint'(out_sum) == 5*cf[0], "R9", "restart after idle", longint'(out_sum), 5*cf[0]);
  endtask

  initial begin
    t_reset_midstream();
    t_latency();
    t_impulse();
    t_step();
    t_random();
    t_gaps();
    t_fullscale(1'b1);
    t_fullscale(1'b0);
    t_flush();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule